// File: doc/BRIEF.md
# Compare-Driven PWM Generator

This block produces two pulse-width-modulated outputs from a single 16-bit up-counter. Each period, the counter starts at a programmable start value, counts once per prescaled tick, and returns to the start value after it reaches a programmable end value. A programmable mid-point value marks the middle of the period. Each output has a turn-on value and a turn-off value, and the output switches when the counter equals one of them. By choosing these values, software gets edge-aligned or center-aligned waveforms. Counting can also be signed (two's complement), so that a period runs symmetrically around zero.

The seven timing values are double-buffered. Software writes a staging copy through a small register port and then pulses a load-OK strobe. The staged set moves into the working set under one of four policies: at once, at the mid-point, at the end of the period, or at either of those. A control word sets the reload policy, signed counting, the polarity of each output, complementary-pair operation with its source channel, and the prescale exponent. A dead-time register delays every rising edge of the pair. A force strobe re-initialises the counter and clears both outputs.

Top module: `pwm_submodule`

## Requirements
- R1: After reset both pins are low, and all staged and working values, the control word and the dead time are zero.
- R2: The counter advances by one on each prescaled tick while `run` is high, and it holds while `run` is low. After a tick at which the counter is at or above the working end value, the counter returns to the working start value. A period therefore lasts end − start + 1 ticks.
- R3: The internal level of channel A is set on the tick at which the counter equals turn-on (address 3). It is cleared on the tick at which the counter equals turn-off (address 4). Channel B works the same way with addresses 5 and 6. Each change reaches the pin one clock later. When turn-on equals turn-off, clear wins and the output stays inactive (0% duty).
- R4: Control bit 2 selects signed comparison for the end-of-period test. With start 0xFFFC and end 3, the period is then 8 ticks.
- R5: Control bits [9:7] hold an exponent p. The counter ticks once every 2^p clocks.
- R6: Writes to addresses 0 to 6 (0 start, 1 mid, 2 end, 3/4 A on/off, 5/6 B on/off) go to the staging set only. They have no effect on the pins until load-OK is pulsed and the reload point arrives.
- R7: Control bits [1:0] select the reload policy: 0 reloads on the clock after load-OK, 1 at the tick where the counter equals mid, 2 at the end-of-period tick, and 3 at either of these.
- R8: Load-OK stays pending until the reload happens. Writes to the staging set while it is pending are discarded.
- R9: Control bit 3 (A) and bit 4 (B) invert the pin, which makes the output low-true.
- R10: When control bit 5 is set, the pair is complementary. Control bit 6 selects B as the source (0 selects A). Output A follows the source and output B follows its inverse. Every rising edge is delayed by the dead-time count (address 8) in clocks, so the two are never high together.
- R11: A force pulse loads the counter with the working start value, clears both internal levels and restarts the prescaler on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0-6 staging, 7 control, 8 dead time) |
| wr_data | input | 16 | Write data |
| ldok_set | input | 1 | Load-OK strobe for the staging set |
| force_init | input | 1 | Re-initialise counter and outputs |
| pwm_a | output | 1 | Channel A pin |
| pwm_b | output | 1 | Channel B pin |

## Verification
The bench targets the places where compare-timed logic most often slips. Turn-on equal to turn-off must give no pulse; a design that lets set win emits a one-tick sliver every period. A staging write issued while load-OK is pending must be dropped; a design that accepts it reloads the later value and shows the wrong width. A mid-point reload that moves turn-off below the current count must stretch the pulse across the wrap into the next period; a design that reloads at the end instead gives a plain pulse. Signed mode with a negative start must give an 8-tick period, where an unsigned end test would lock the counter. Dead time must shorten each high phase of the complementary pair by exactly the programmed count.

// File: rtl/pwm_sm_pkg.sv
package pwm_sm_pkg;

   // staging/working compare slots, their position is the write address
   localparam int NUM_CMP  = 7;
   localparam int IX_START = 0;
   localparam int IX_MID   = 1;
   localparam int IX_END   = 2;
   localparam int IX_AON   = 3;
   localparam int IX_AOFF  = 4;
   localparam int IX_BON   = 5;
   localparam int IX_BOFF  = 6;

   localparam int ADDR_CTRL = 7;
   localparam int ADDR_DEAD = 8;

   localparam int PRSC_W = 3;

   typedef enum logic [1:0] {
      RLD_NOW  = 2'd0,
      RLD_MID  = 2'd1,
      RLD_END  = 2'd2,
      RLD_BOTH = 2'd3
   } reload_e;

   typedef struct packed {
      logic [PRSC_W-1:0] prsc;
      logic              src_b;
      logic              comp;
      logic              pol_b;
      logic              pol_a;
      logic              sgn;
      reload_e           policy;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_sm_prescale.sv
module pwm_sm_prescale #(
   parameter int EXP_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic             tick_o
);
   localparam int DIV_W = (1 << EXP_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   always_comb begin
      mask   = (DIV_W'(1) << exp_i) - DIV_W'(1);
      tick_o = run_i && ((div_q & mask) == mask);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               div_q <= '0;
      else if (clr_i || !run_i)  div_q <= '0;
      else                       div_q <= div_q + DIV_W'(1);
   end

   // R5: with a non-zero exponent two ticks never come back to back
   p_tick_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && exp_i != '0 && !clr_i) |=> (!tick_o || exp_i != $past(exp_i)));

endmodule

// File: rtl/pwm_sm_timebase.sv
module pwm_sm_timebase
   import pwm_sm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic              tick_i,
   input  logic              force_i,
   input  logic              sgn_i,
   input  reload_e           policy_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   input  logic              ldok_set_i,
   output logic [1:0]        raw_o
);
   localparam int IX_W = $clog2(NUM_CMP);

   logic [NUM_CMP-1:0][CNT_W-1:0] stage_q, work_q;
   logic [CNT_W-1:0]              cnt_q;
   logic                          ldok_q;
   logic                          step, at_end, mid_hit, reload_now, wr_hit;

   always_comb begin
      step    = run_i && tick_i;
      at_end  = sgn_i ? ($signed(cnt_q) >= $signed(work_q[IX_END]))
                      : (cnt_q >= work_q[IX_END]);
      mid_hit = (cnt_q == work_q[IX_MID]);
      unique case (policy_i)
         RLD_NOW: reload_now = ldok_q;
         RLD_MID: reload_now = ldok_q && step && mid_hit;
         RLD_END: reload_now = ldok_q && step && at_end;
         default: reload_now = ldok_q && step && (mid_hit || at_end);
      endcase
      wr_hit = wr_en_i && !ldok_q && (wr_addr_i < ADDR_W'(NUM_CMP));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q <= '0;
      else if (wr_hit) stage_q[wr_addr_i[IX_W-1:0]] <= wr_data_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ldok_q <= 1'b0;
         work_q <= '0;
      end else if (reload_now) begin
         ldok_q <= 1'b0;
         work_q <= stage_q;
      end else if (ldok_set_i) begin
         ldok_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (force_i)  cnt_q <= work_q[IX_START];
      else if (step) begin
         if (at_end) cnt_q <= reload_now ? stage_q[IX_START] : work_q[IX_START];
         else        cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      localparam int ON_IX  = IX_AON + 2 * ch;
      localparam int OFF_IX = ON_IX + 1;
      logic lvl_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      lvl_q <= 1'b0;
         else if (force_i) lvl_q <= 1'b0;
         else if (step) begin
            if (cnt_q == work_q[OFF_IX])     lvl_q <= 1'b0;
            else if (cnt_q == work_q[ON_IX]) lvl_q <= 1'b1;
         end
      end
      assign raw_o[ch] = lvl_q;

      // R3: equal on/off values never let an inactive channel turn on
      p_zero_duty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!lvl_q && work_q[ON_IX] == work_q[OFF_IX]) |=> !lvl_q);
   end

   // R8: the staging set is frozen while load-OK is pending
   p_stage_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ldok_q |=> $stable(stage_q));

   // R7: end-of-period policy keeps load-OK pending until the wrap tick
   p_hold_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ldok_q && policy_i == RLD_END && !(step && at_end)) |=> ldok_q);

   // R2: a wrap without reload returns to the working start value
   p_wrap_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step && at_end && !force_i && !reload_now) |=> (cnt_q == $past(work_q[IX_START])));

   // R11: force restarts the counter and clears both levels
   p_force_init_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_i |=> (cnt_q == $past(work_q[IX_START]) && raw_o == 2'b00));

endmodule

// File: rtl/pwm_sm_deadband.sv
module pwm_sm_deadband #(
   parameter int DT_W = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            in_i,
   input  logic [DT_W-1:0] dt_i,
   output logic            out_o
);
   logic [DT_W-1:0] wait_q;
   logic            out_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wait_q <= '0;
         out_q  <= 1'b0;
      end else if (!in_i) begin
         wait_q <= '0;
         out_q  <= 1'b0;
      end else if (wait_q >= dt_i) begin
         out_q  <= 1'b1;
      end else begin
         wait_q <= wait_q + DT_W'(1);
      end
   end

   assign out_o = out_q;

   // R10: an output only rises while its request was already high
   p_rise_requested_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(out_q) |-> $past(in_i));

endmodule

// File: rtl/pwm_submodule.sv
module pwm_submodule
   import pwm_sm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DT_W   = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              ldok_set,
   input  logic              force_init,
   output logic              pwm_a,
   output logic              pwm_b
);
   if (CNT_W < CTRL_W) begin : g_bad_cnt_w
      $error("CNT_W must hold the control word");
   end
   if (DT_W < 1 || DT_W > CNT_W) begin : g_bad_dt_w
      $error("DT_W must be between 1 and CNT_W");
   end
   if (ADDR_W < $clog2(ADDR_DEAD + 1)) begin : g_bad_addr_w
      $error("ADDR_W too small for the register map");
   end

   ctrl_t           ctrl_q;
   logic [DT_W-1:0] dt_q;
   logic            tick;
   logic [1:0]      raw, db_in, core;
   logic            src;
   logic [DT_W-1:0] dt_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         dt_q   <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(ADDR_CTRL)) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (wr_addr == ADDR_W'(ADDR_DEAD)) dt_q   <= wr_data[DT_W-1:0];
      end
   end

   pwm_sm_prescale #(.EXP_W(PRSC_W)) u_prescale (
      .clk_i (clk),
      .rst_ni(rst_n),
      .run_i (run),
      .clr_i (force_init),
      .exp_i (ctrl_q.prsc),
      .tick_o(tick)
   );

   pwm_sm_timebase #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_timebase (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .run_i     (run),
      .tick_i    (tick),
      .force_i   (force_init),
      .sgn_i     (ctrl_q.sgn),
      .policy_i  (ctrl_q.policy),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .ldok_set_i(ldok_set),
      .raw_o     (raw)
   );

   always_comb begin
      src      = ctrl_q.src_b ? raw[1] : raw[0];
      db_in[0] = ctrl_q.comp ? src  : raw[0];
      db_in[1] = ctrl_q.comp ? !src : raw[1];
      dt_eff   = ctrl_q.comp ? dt_q : '0;
   end

   for (genvar ch = 0; ch < 2; ch++) begin : g_out
      pwm_sm_deadband #(.DT_W(DT_W)) u_db (
         .clk_i (clk),
         .rst_ni(rst_n),
         .in_i  (db_in[ch]),
         .dt_i  (dt_eff),
         .out_o (core[ch])
      );
   end

   assign pwm_a = core[0] ^ ctrl_q.pol_a;
   assign pwm_b = core[1] ^ ctrl_q.pol_b;

   // R10: a settled complementary pair is never active on both sides
   p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.comp && $past(ctrl_q.comp) && $past(ctrl_q.comp, 2)) |-> !(core[0] && core[1]));

   // R9: the pin equals the core level unless its polarity bit is set
   p_polarity_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.pol_a |-> (pwm_a == core[0]));

endmodule

// File: tb/sim_pwm_submodule.sv
`timescale 1ns/1ps
module sim_pwm_submodule;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        ldok_set = 1'b0;
   logic        force_init = 1'b0;
   logic        pwm_a, pwm_b;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwm_submodule u0 (
      .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ldok_set(ldok_set), .force_init(force_init),
      .pwm_a(pwm_a), .pwm_b(pwm_b)
   );

   function automatic logic [15:0] ctrlw(input int pol, input bit sgn, input bit pa,
                                         input bit pb, input bit comp, input bit srcb,
                                         input int prsc);
      return {6'd0, 3'(prsc), srcb, comp, pb, pa, sgn, 2'(pol)};
   endfunction

   function automatic bit pin(input int ch, input bit inv);
      return ((ch == 0) ? pwm_a : pwm_b) ^ inv;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 16'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ldok();
      @(negedge clk);
      ldok_set = 1'b1;
      @(negedge clk);
      ldok_set = 1'b0;
   endtask

   task automatic wait_rise(input int ch, input bit inv);
      int n = 0;
      while (pin(ch, inv) && n < 2000) begin @(negedge clk); n++; end
      while (!pin(ch, inv) && n < 2000) begin @(negedge clk); n++; end
   endtask

   task automatic measure(input int ch, input bit inv, output int hi, output int per);
      int lo = 0;
      hi = 0;
      wait_rise(ch, inv);
      while (pin(ch, inv) && hi < 2000) begin hi++; @(negedge clk); end
      while (!pin(ch, inv) && lo < 2000) begin lo++; @(negedge clk); end
      per = hi + lo;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 pin A after reset", pwm_a, 0);
      chk("R1 pin B after reset", pwm_b, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run = 1'b1;
   endtask

   task automatic load_base();
      wr(7, ctrlw(0, 0, 0, 0, 0, 0, 0));
      wr(0, 0); wr(1, 5); wr(2, 9); wr(3, 0); wr(4, 3); wr(5, 2); wr(6, 7);
      ldok();
      repeat (30) @(negedge clk);
   endtask

   task automatic t_edge();
      int hi, per;
      load_base();
      measure(0, 0, hi, per);
      chk("R3 A width", hi, 3);
      chk("R2 A period", per, 10);
      measure(1, 0, hi, per);
      chk("R3 B width", hi, 5);
      chk("R2 B period", per, 10);
   endtask

   task automatic t_zero_duty();
      int seen = 0;
      wr(4, 0); ldok();
      repeat (20) @(negedge clk);
      for (int i = 0; i < 40; i++) begin @(negedge clk); seen += int'(pwm_a); end
      chk("R3 equal on/off gives no pulse", seen, 0);
      wr(4, 3); ldok();
      repeat (20) @(negedge clk);
   endtask

   task automatic t_prescale();
      int hi, per;
      wr(7, ctrlw(0, 0, 0, 0, 0, 0, 2));
      repeat (100) @(negedge clk);
      measure(0, 0, hi, per);
      chk("R5 A width with p=2", hi, 12);
      chk("R5 A period with p=2", per, 40);
      wr(7, ctrlw(0, 0, 0, 0, 0, 0, 0));
   endtask

   task automatic t_signed();
      int hi, per;
      wr(7, ctrlw(0, 1, 0, 0, 0, 0, 0));
      wr(0, 16'hFFFC); wr(1, 0); wr(2, 3); wr(3, 16'hFFFC); wr(4, 16'hFFFE);
      ldok();
      repeat (40) @(negedge clk);
      measure(0, 0, hi, per);
      chk("R4 signed A width", hi, 2);
      chk("R4 signed period", per, 8);
      load_base();
   endtask

   task automatic t_pending();
      int hi, per;
      wr(7, ctrlw(2, 0, 0, 0, 0, 0, 0));
      wr(4, 6);
      repeat (30) @(negedge clk);
      measure(0, 0, hi, per);
      chk("R6 staged write without load-OK has no effect", hi, 3);
      wait_rise(0, 0);
      while (pwm_a) @(negedge clk);
      ldok_set = 1'b1;
      @(negedge clk);
      ldok_set = 1'b0;
      wr_en = 1'b1; wr_addr = 4'd4; wr_data = 16'd8;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (20) @(negedge clk);
      measure(0, 0, hi, per);
      chk("R8 write during pending load-OK discarded", hi, 6);
      chk("R7 end-of-period reload keeps period", per, 10);
   endtask

   task automatic t_half();
      int hi, per;
      wr(7, ctrlw(1, 0, 0, 0, 0, 0, 0));
      wr(4, 2);
      repeat (20) @(negedge clk);
      wait_rise(0, 0);
      ldok_set = 1'b1;
      hi = 1;
      @(negedge clk);
      ldok_set = 1'b0;
      while (pwm_a && hi < 2000) begin hi++; @(negedge clk); end
      chk("R7 mid-point reload stretches pulse across wrap", hi, 12);
      measure(0, 0, hi, per);
      chk("R7 width after mid-point reload", hi, 2);
   endtask

   task automatic t_polarity();
      int hi, per;
      wr(7, ctrlw(0, 0, 1, 1, 0, 0, 0));
      repeat (20) @(negedge clk);
      measure(0, 1, hi, per);
      chk("R9 A low-true width", hi, 2);
      measure(1, 1, hi, per);
      chk("R9 B low-true width", hi, 5);
   endtask

   task automatic t_comp();
      int hi, per;
      wr(4, 3); ldok();
      wr(8, 2);
      wr(7, ctrlw(0, 0, 0, 0, 1, 0, 0));
      repeat (30) @(negedge clk);
      measure(0, 0, hi, per);
      chk("R10 A width shortened by dead time", hi, 1);
      chk("R10 A period", per, 10);
      measure(1, 0, hi, per);
      chk("R10 B complement width shortened by dead time", hi, 5);
      wr(7, ctrlw(0, 0, 0, 0, 1, 1, 0));
      repeat (30) @(negedge clk);
      measure(0, 0, hi, per);
      chk("R10 B selected as source", hi, 3);
   endtask

   task automatic t_force();
      int n = 0;
      wr(7, ctrlw(0, 0, 0, 0, 0, 0, 0));
      wr(8, 0);
      repeat (20) @(negedge clk);
      wait_rise(0, 0);
      run = 1'b0;
      repeat (5) @(negedge clk);
      chk("R2 output holds while run is low", pwm_a, 1);
      force_init = 1'b1;
      @(negedge clk);
      force_init = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 force clears output", pwm_a, 0);
      run = 1'b1;
      while (!pwm_a && n < 100) begin @(negedge clk); n++; end
      chk("R11 restart from start value", n, 2);
   endtask

   initial begin
      t_reset();
      t_edge();
      t_zero_duty();
      t_prescale();
      t_signed();
      t_pending();
      t_half();
      t_polarity();
      t_comp();
      t_force();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule